// File: doc/BRIEF.md
# Rainbow Chain Precomputation Engine

This block builds the (start point, end point) pairs of a time-memory trade-off table over a reduced key space. Each chain starts from one start point. A fixed chosen plaintext is encrypted with the current point as the key. The ciphertext is then reduced to a new point, and that point becomes the key for the next column. After a set number of columns the chain's final point is its end point, and the engine emits the start point together with that end point.

The cipher is modelled by a fixed-latency pipelined mixing function. A single multiplexer at the pipeline entry chooses what goes in on each cycle. It takes either a chain returning from the pipeline's tail for its next column, or a fresh start point. This lets one pipeline carry as many chains at once as it has stages. Start points are issued in ascending order from the first value to the last. The plaintext is permuted once when a run begins and is then held. Storing the pairs is left to whatever consumes the valid-qualified pair stream.

Top module: `rainbow_chain_gen`

## Requirements
- R1: After a clock edge with `rst_n` low, `pair_valid` and `run_done` are 0 and the engine is idle.
- R2: A run starts at the first edge in the idle state where `enable` is 1. At that edge the engine captures `plaintext`, `first_start`, `last_start`, `start_mask` and `end_mask`. Changing these inputs later in the run has no effect on any emitted pair.
- R3: Each counter value v from `first_start` to `last_start` inclusive is issued exactly once, in ascending order. The issued start point is v AND `start_mask`. Pairs leave in issue order, one per start point. The counter is 57 bits wide, so a last value of all ones does not wrap.
- R4: End-point function: P0 = rotl64(plaintext, 24). For each column c from 0 to CHAIN_LEN-1, with key k, set x = P0 and apply STAGES rounds. Each round computes K = {k, k[55:48]}, then x = rotl64(x ^ K, 13) + K (mod 2^64). Then y = rotr64(x, 24), and the next key is k = (y[55:0] ^ y[63:56] ^ c) & end_mask. The end point is the key after column CHAIN_LEN-1.
- R5: With pause low, a new chain enters on every cycle while start points remain and a slot is free. A chain whose start point enters on edge t has its pair on the ports after edge t + CHAIN_LEN*STAGES. The first pair therefore appears 1 + CHAIN_LEN*STAGES edges after the starting edge.
- R6: While `pause` is 1, no chain advances or enters and `pair_valid` is 0. When pause is released, every pair is the same as in an unpaused run, each delayed by the number of paused cycles.
- R7: `run_done` rises on the edge after the final chain's pair and stays high until reset, with no further pairs. If `first_start` > `last_start`, `run_done` rises with no pair at all.
- R8: `enable` is ignored while a run is in progress or finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Starts a run when the engine is idle |
| pause | input | 1 | Freezes generation while high |
| plaintext | input | 64 | Chosen plaintext |
| first_start | input | 56 | First start-point counter value |
| last_start | input | 56 | Last start-point counter value |
| start_mask | input | 56 | Mask applied to issued start points |
| end_mask | input | 56 | Mask applied to every reduced point |
| pair_valid | output | 1 | A pair is present this cycle |
| pair_start | output | 56 | Start point of the emitted chain |
| pair_end | output | 56 | End point of the emitted chain |
| run_done | output | 1 | All chains of the run have been emitted |

## Verification
Any corruption of a slot's key, column count or origin stays hidden until that slot completes its chain. It then shows up as a wrong end point, a wrong start point, or a pair that arrives early, late or out of order. All of these appear at most CHAIN_LEN*STAGES cycles after the fault. A fault in the issue counter or run control shows up as a missing, duplicated or extra pair, or as `run_done` rising too early or too late. The bench therefore predicts, on every cycle, whether a pair is valid, its exact contents and the done flag. It covers runs with mixed pause patterns, masked start points, an empty range and an all-ones range.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int BLK_W = 64;
    localparam int KEY_W = 56;
    localparam int COL_W = 16;
    localparam int PERM_ROT = 24;
    localparam int MIX_ROT = 13;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [KEY_W-1:0] key_t;
    typedef logic [COL_W-1:0] col_t;

    // one chain in flight
    typedef struct packed {
        logic valid;
        key_t origin;
        key_t key;
        col_t col;
        blk_t state;
    } slot_t;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_BUSY = 2'd1,
        RUN_FIN  = 2'd2
    } run_e;

    function automatic blk_t perm_in(input blk_t x);
        return {x[BLK_W-PERM_ROT-1:0], x[BLK_W-1:BLK_W-PERM_ROT]};
    endfunction

    function automatic blk_t perm_out(input blk_t x);
        return {x[PERM_ROT-1:0], x[BLK_W-1:PERM_ROT]};
    endfunction

    function automatic blk_t spread_key(input key_t k);
        return {k, k[KEY_W-1:KEY_W-(BLK_W-KEY_W)]};
    endfunction

    function automatic blk_t mix_round(input blk_t x, input key_t k);
        blk_t kk;
        blk_t y;
        kk = spread_key(k);
        y  = x ^ kk;
        y  = {y[BLK_W-MIX_ROT-1:0], y[BLK_W-1:BLK_W-MIX_ROT]};
        return y + kk;
    endfunction

    function automatic key_t reduce_pt(input blk_t ct, input col_t col, input key_t msk);
        key_t fold;
        fold = ct[KEY_W-1:0] ^ {{(KEY_W-(BLK_W-KEY_W)){1'b0}}, ct[BLK_W-1:KEY_W]};
        return (fold ^ {{(KEY_W-COL_W){1'b0}}, col}) & msk;
    endfunction

endpackage

// File: rtl/rcp_issue.sv
module rcp_issue
    import rcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  blk_t plaintext,
    input  key_t first_start,
    input  key_t last_start,
    input  key_t start_mask,
    input  key_t end_mask,
    input  logic take,
    input  logic pipe_busy,
    output logic running,
    output logic done,
    output logic have_start,
    output key_t start_pt,
    output blk_t ptx_q,
    output key_t emask_q
);

    run_e           st_q;
    logic [KEY_W:0] nxt_q;
    logic [KEY_W:0] last_q;
    key_t           smask_q;
    logic           exhausted;

    assign exhausted  = nxt_q > last_q;
    assign running    = (st_q == RUN_BUSY);
    assign done       = (st_q == RUN_FIN);
    assign have_start = running && !exhausted;
    assign start_pt   = nxt_q[KEY_W-1:0] & smask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RUN_IDLE;
            nxt_q   <= '0;
            last_q  <= '0;
            smask_q <= '0;
            emask_q <= '0;
            ptx_q   <= '0;
        end else begin
            unique case (st_q)
                RUN_IDLE: begin
                    if (enable) begin
                        st_q    <= RUN_BUSY;
                        nxt_q   <= {1'b0, first_start};
                        last_q  <= {1'b0, last_start};
                        smask_q <= start_mask;
                        emask_q <= end_mask;
                        ptx_q   <= perm_in(plaintext);
                    end
                end
                RUN_BUSY: begin
                    if (take) begin
                        nxt_q <= nxt_q + 1'b1;
                    end
                    if (exhausted && !pipe_busy) begin
                        st_q <= RUN_FIN;
                    end
                end
                default: st_q <= RUN_FIN;
            endcase
        end
    end

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R3
    issue_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (nxt_q >= $past(nxt_q)));

endmodule

// File: rtl/rcp_mix_pipe.sv
module rcp_mix_pipe
    import rcp_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  blk_t  ptx,
    input  slot_t entry,
    output slot_t tail,
    output logic  busy
);

    logic [STAGES-1:0] vld;

    for (genvar i = 0; i < STAGES; i++) begin : stg
        slot_t q;
        slot_t nx;
        if (i == 0) begin : g_head
            always_comb begin
                nx       = entry;
                nx.state = mix_round(ptx, entry.key);
            end
        end else begin : g_body
            always_comb begin
                nx       = stg[i-1].q;
                nx.state = mix_round(stg[i-1].q.state, stg[i-1].q.key);
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (adv) begin
                q <= nx;
            end
        end
        assign vld[i] = q.valid;
    end

    assign tail = stg[STAGES-1].q;
    assign busy = |vld;

    // R6
    pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(tail));

endmodule

// File: rtl/rcp_recycle.sv
module rcp_recycle
    import rcp_pkg::*;
#(
    parameter int CHAIN_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  slot_t tail,
    input  logic  have_start,
    input  key_t  start_pt,
    input  key_t  emask,
    output slot_t entry,
    output logic  take,
    output logic  pair_valid,
    output key_t  pair_start,
    output key_t  pair_end
);

    localparam col_t LAST_COL = col_t'(CHAIN_LEN - 1);

    key_t red;
    logic last_col;
    logic cont;

    assign red      = reduce_pt(perm_out(tail.state), tail.col, emask);
    assign last_col = tail.valid && (tail.col == LAST_COL);
    assign cont     = tail.valid && !last_col;
    assign take     = adv && !cont && have_start;

    always_comb begin
        entry = '0;
        if (cont) begin
            entry.valid  = 1'b1;
            entry.origin = tail.origin;
            entry.key    = red;
            entry.col    = tail.col + 1'b1;
        end else if (have_start) begin
            entry.valid  = 1'b1;
            entry.origin = start_pt;
            entry.key    = start_pt;
            entry.col    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
            pair_start <= '0;
            pair_end   <= '0;
        end else begin
            pair_valid <= adv && last_col;
            if (adv && last_col) begin
                pair_start <= tail.origin;
                pair_end   <= red;
            end
        end
    end

endmodule

// File: rtl/rainbow_chain_gen.sv
module rainbow_chain_gen
    import rcp_pkg::*;
#(
    parameter int STAGES    = 3,
    parameter int CHAIN_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        pause,
    input  logic [63:0] plaintext,
    input  logic [55:0] first_start,
    input  logic [55:0] last_start,
    input  logic [55:0] start_mask,
    input  logic [55:0] end_mask,
    output logic        pair_valid,
    output logic [55:0] pair_start,
    output logic [55:0] pair_end,
    output logic        run_done
);

    logic  running;
    logic  have_start;
    logic  take;
    logic  busy;
    logic  adv;
    key_t  start_pt;
    key_t  emask_q;
    blk_t  ptx_q;
    slot_t entry;
    slot_t tail;

    assign adv = running && !pause;

    rcp_issue u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .plaintext   (plaintext),
        .first_start (first_start),
        .last_start  (last_start),
        .start_mask  (start_mask),
        .end_mask    (end_mask),
        .take        (take),
        .pipe_busy   (busy),
        .running     (running),
        .done        (run_done),
        .have_start  (have_start),
        .start_pt    (start_pt),
        .ptx_q       (ptx_q),
        .emask_q     (emask_q)
    );

    rcp_mix_pipe #(.STAGES(STAGES)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .ptx   (ptx_q),
        .entry (entry),
        .tail  (tail),
        .busy  (busy)
    );

    rcp_recycle #(.CHAIN_LEN(CHAIN_LEN)) u_recycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .tail       (tail),
        .have_start (have_start),
        .start_pt   (start_pt),
        .emask      (emask_q),
        .entry      (entry),
        .take       (take),
        .pair_valid (pair_valid),
        .pair_start (pair_start),
        .pair_end   (pair_end)
    );

    // R7
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> !pair_valid);

    // R6
    pause_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pause) |=> !pair_valid);

endmodule

// File: tb/rainbow_chain_gen_test.sv
module rainbow_chain_gen_test;

    localparam int CLK_NS = 10;
    localparam int ST     = 3;
    localparam int CL     = 4;
    localparam int WDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        pause = 1'b0;
    logic [63:0] plaintext = '0;
    logic [55:0] first_start = '0;
    logic [55:0] last_start = '0;
    logic [55:0] start_mask = '0;
    logic [55:0] end_mask = '0;
    logic        pair_valid;
    logic [55:0] pair_start;
    logic [55:0] pair_end;
    logic        run_done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int run_edge = 0;
    int first_pair_cyc = -1;
    int pairs_seen = 0;
    bit cmp_on = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    rainbow_chain_gen #(.STAGES(ST), .CHAIN_LEN(CL)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pause(pause),
        .plaintext(plaintext), .first_start(first_start), .last_start(last_start),
        .start_mask(start_mask), .end_mask(end_mask),
        .pair_valid(pair_valid), .pair_start(pair_start), .pair_end(pair_end),
        .run_done(run_done)
    );

    // ---------------- reference model ----------------
    int          m_st = 0;          // 0 idle, 1 busy, 2 finished
    logic [56:0] m_next = '0;
    logic [56:0] m_last = '0;
    logic [55:0] m_smask = '0;
    logic [55:0] m_emask = '0;
    logic [63:0] m_pt = '0;
    bit          q_v[$];
    logic [55:0] q_s[$];
    int          q_c[$];
    bit          e_valid = 1'b0;
    logic [55:0] e_start = '0;
    logic [55:0] e_end = '0;
    bit          e_done = 1'b0;

    function automatic logic [63:0] rl(input logic [63:0] x, input int n);
        return (x << n) | (x >> (64 - n));
    endfunction

    function automatic logic [55:0] chain_end(input logic [55:0] sp, input logic [63:0] pt,
                                              input logic [55:0] em);
        logic [55:0] k;
        logic [63:0] x;
        logic [63:0] kk;
        k = sp;
        for (int c = 0; c < CL; c++) begin
            x = rl(pt, 24);
            for (int s = 0; s < ST; s++) begin
                kk = {k, k[55:48]};
                x  = rl(x ^ kk, 13) + kk;
            end
            x = rl(x, 40);
            k = (x[55:0] ^ {48'h0, x[63:56]} ^ 56'(c)) & em;
        end
        return k;
    endfunction

    always @(posedge clk) begin
        bit tv;
        logic [55:0] ts;
        int tc;
        bit empty;
        cyc++;
        e_valid = 1'b0;
        if (!rst_n) begin
            m_st = 0;
            q_v.delete(); q_s.delete(); q_c.delete();
            for (int i = 0; i < ST; i++) begin
                q_v.push_back(1'b0); q_s.push_back('0); q_c.push_back(0);
            end
        end else if (m_st == 0) begin
            if (enable) begin
                m_st = 1; m_next = {1'b0, first_start}; m_last = {1'b0, last_start};
                m_smask = start_mask; m_emask = end_mask; m_pt = plaintext;
                run_edge = cyc;
            end
        end else if (m_st == 1) begin
            empty = 1'b1;
            foreach (q_v[i]) if (q_v[i]) empty = 1'b0;
            if (m_next > m_last && empty) m_st = 2;
            if (!pause) begin
                tv = q_v.pop_front(); ts = q_s.pop_front(); tc = q_c.pop_front();
                if (tv && tc == CL - 1) begin
                    e_valid = 1'b1; e_start = ts;
                    e_end = chain_end(ts, m_pt, m_emask);
                end
                if (tv && tc < CL - 1) begin
                    q_v.push_back(1'b1); q_s.push_back(ts); q_c.push_back(tc + 1);
                end else if (m_next <= m_last) begin
                    q_v.push_back(1'b1); q_s.push_back(m_next[55:0] & m_smask); q_c.push_back(0);
                    m_next = m_next + 1;
                end else begin
                    q_v.push_back(1'b0); q_s.push_back('0); q_c.push_back(0);
                end
            end
        end
        e_done = (m_st == 2);
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(pair_valid === e_valid, "R5 R6 pair_valid", 64'(pair_valid), 64'(e_valid));
            if (e_valid) begin
                chk(pair_start === e_start, "R3 pair_start", 64'(pair_start), 64'(e_start));
                chk(pair_end === e_end, "R4 pair_end", 64'(pair_end), 64'(e_end));
            end
            chk(run_done === e_done, "R7 run_done", 64'(run_done), 64'(e_done));
            if (pair_valid === 1'b1) begin
                pairs_seen++;
                if (first_pair_cyc < 0) first_pair_cyc = cyc;
            end
        end
        if (cyc > WDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; pause = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pairs_seen = 0;
        first_pair_cyc = -1;
    endtask

    task automatic start_run(input logic [63:0] pt, input logic [55:0] f, input logic [55:0] l,
                             input logic [55:0] sm, input logic [55:0] em);
        plaintext = pt; first_start = f; last_start = l; start_mask = sm; end_mask = em;
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (run_done === 1'b1) return;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pair_valid === 1'b0, "R1 pair_valid after reset", 64'(pair_valid), 64'h0);
        chk(run_done === 1'b0, "R1 run_done after reset", 64'(run_done), 64'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        pairs_seen = 0;

        // Run A: 11 chains, inputs disturbed mid-run (R2, R8), timing (R5)
        start_run(64'h0123_4567_89AB_CDEF, 56'd100, 56'd110, {56{1'b1}}, 56'h00_00FF_FFFF_FFFF);
        repeat (4) @(negedge clk);
        plaintext = 64'hFFFF_0000_FFFF_0000; first_start = 56'd3; last_start = 56'd9;
        end_mask = 56'hFF; enable = 1'b1;
        repeat (3) @(negedge clk);
        enable = 1'b0;
        wait_done(2000);
        chk(pairs_seen == 11, "R3 R2 pair count run A", 64'(pairs_seen), 64'd11);
        chk(first_pair_cyc - run_edge == 1 + CL * ST, "R5 first pair latency",
            64'(first_pair_cyc - run_edge), 64'(1 + CL * ST));

        // Run B: masked start points, pause patterns (R6, R3)
        do_reset();
        start_run(64'hDEAD_BEEF_0BAD_F00D, 56'hAB_0000_0000_0007, 56'hAB_0000_0000_0010,
                  56'h00_00FF_FFFF_FFFF, 56'h00_0000_00FF_FFFF);
        repeat (5) @(negedge clk);
        pause = 1'b1;
        repeat (7) @(negedge clk);
        pause = 1'b0;
        for (int i = 0; i < 40; i++) begin
            pause = (i % 3 == 1);
            @(negedge clk);
        end
        pause = 1'b0;
        wait_done(2000);
        chk(pairs_seen == 10, "R3 R6 pair count run B", 64'(pairs_seen), 64'd10);

        // Run C: empty range (R7)
        do_reset();
        start_run(64'h1111_2222_3333_4444, 56'd50, 56'd49, {56{1'b1}}, {56{1'b1}});
        wait_done(50);
        repeat (3) @(negedge clk);
        chk(pairs_seen == 0, "R7 empty range no pairs", 64'(pairs_seen), 64'd0);
        chk(run_done === 1'b1, "R7 empty range done", 64'(run_done), 64'd1);

        // Run D: all-ones single chain, no wrap (R3), sticky done (R7, R8)
        do_reset();
        start_run(64'h8000_0000_0000_0001, {56{1'b1}}, {56{1'b1}}, {56{1'b1}}, {56{1'b1}});
        wait_done(500);
        chk(pairs_seen == 1, "R3 all-ones range single pair", 64'(pairs_seen), 64'd1);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        enable = 1'b0;
        chk(run_done === 1'b1, "R7 R8 done sticky", 64'(run_done), 64'd1);
        chk(pairs_seen == 1, "R8 no restart after done", 64'(pairs_seen), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule